// File: doc/BRIEF.md
# Multi-Pool Free Buffer Pointer Allocator

This block keeps lists of free buffer pointers for up to eight independent pools in a single shared on-chip pointer store. A producer that releases a buffer issues a free command naming a pool and a pointer. A consumer that needs a buffer issues an alloc command naming a pool. One cycle later it receives the oldest pointer in that pool, or an all-zero pointer when the pool has nothing to give.

Each pool has a size setting. The sizes split the store into back-to-back regions, with pool 0 lowest and each later pool placed directly after the one before it. Inside its region a pool works as a circular FIFO. The low bit of each size is ignored, and two slots of every region are held back, so a region of size S holds at most S-2 pointers. A global enable gates all traffic. Any size write starts a settling window during which the block refuses work. A select port reads back the number of pointers held by any pool.

Top module: `fpool_alloc`

## Requirements
- R1: After reset every pool holds zero pointers, `ready` is 1, the enable is off, and `alloc_done` and `free_drop` are 0.
- R2: Size bit 0 is ignored (a written size of 5 acts as 4). Pool p's region starts at the sum of the even sizes of pools 0..p-1, so pointers held in different pools never disturb each other.
- R3: A pool of even size S holds at most S-2 pointers (0 when S is below 2). A free to a full pool is dropped, the count is unchanged, and `free_drop` is 1 in the cycle after the command.
- R4: Allocs from a pool return its pointers in the order they were freed, including after the region's slots wrap around.
- R5: Every alloc command sets `alloc_done` in the next cycle. If the pool was empty, `alloc_ptr` is all zeros in that cycle.
- R6: While the enable is off, an alloc returns all zeros and a free changes no count.
- R7: A size write drives `ready` low for 10 cycles and empties every pool. While `ready` is low, alloc returns zero and free is ignored.
- R8: `stat_count` shows, at once, the number of pointers held by the pool on `stat_pool`. The number is the accepted frees minus the successful allocs since the last clear.
- R9: An alloc and a free to different pools in the same cycle both complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write a pool size |
| cfg_pool | input | 3 | Pool addressed by the size write |
| cfg_size | input | 12 | Region size; bit 0 ignored |
| ctrl_wr | input | 1 | Write the global enable |
| ctrl_enable | input | 1 | Enable value to store |
| free_valid | input | 1 | Free command |
| free_pool | input | 3 | Pool receiving the pointer |
| free_ptr | input | 32 | Pointer being released |
| alloc_valid | input | 1 | Alloc command |
| alloc_pool | input | 3 | Pool to take a pointer from |
| alloc_done | output | 1 | Alloc result valid, one cycle after the command |
| alloc_ptr | output | 32 | Allocated pointer, or zero |
| free_drop | output | 1 | Previous free hit a full pool |
| ready | output | 1 | Settling window after a size write has ended |
| stat_pool | input | 3 | Pool whose count is shown |
| stat_count | output | 26 | Pointers held by the selected pool |

## Verification
On every cycle the assertions check four things. No pool count ever exceeds its region's usable limit. `ready` is low after each size write. Every alloc is answered on the next cycle, and an alloc refused by the enable or by the settling window yields zero. A drop only ever follows a free. The bench scenarios are what show the rest. Pointers come back in FIFO order across a wrap. The odd-size rounding gives a pool the expected capacity, and neighbouring regions stay separate. An empty pool answers with zero, and a same-cycle alloc and free to two pools both take effect.

// File: rtl/fpool_pkg.sv
package fpool_pkg;
  localparam int FP_NUM_POOLS = 8;
  localparam int FP_SZ_W      = 12;
  localparam int FP_DEPTH     = 2048;
  localparam int FP_PTR_W     = 32;
  localparam int FP_CNT_W     = 26;
  localparam int FP_READY_DLY = 10;
  localparam int FP_RESERVE   = 2;
endpackage

// File: rtl/fpool_cfg.sv
module fpool_cfg #(
  parameter int NUM_POOLS = fpool_pkg::FP_NUM_POOLS,
  parameter int SZ_W      = fpool_pkg::FP_SZ_W,
  parameter int READY_DLY = fpool_pkg::FP_READY_DLY,
  parameter int RESERVE   = fpool_pkg::FP_RESERVE,
  parameter int PW        = $clog2(NUM_POOLS),
  parameter int BASE_W    = SZ_W + PW
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_wr,
  input  logic [PW-1:0]                   cfg_pool,
  input  logic [SZ_W-1:0]                 cfg_size,
  input  logic                            ctrl_wr,
  input  logic                            ctrl_enable,
  output logic [NUM_POOLS-1:0][SZ_W-1:0]  size_even,
  output logic [NUM_POOLS-1:0][SZ_W-1:0]  cap,
  output logic [NUM_POOLS-1:0][BASE_W-1:0] base,
  output logic                            ready,
  output logic                            enable
);
  localparam int DLY_W = $clog2(READY_DLY + 1);

  logic [NUM_POOLS-1:0][SZ_W-1:0] size_q, size_d;
  logic [DLY_W-1:0]               wait_q, wait_d;
  logic                           en_q, en_d;

  always_comb begin
    size_d = size_q;
    if (cfg_wr) size_d[cfg_pool] = cfg_size;
    en_d = ctrl_wr ? ctrl_enable : en_q;
    if (cfg_wr)              wait_d = DLY_W'(READY_DLY);
    else if (wait_q != '0)   wait_d = wait_q - 1'b1;
    else                     wait_d = wait_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      wait_q <= '0;
      en_q   <= 1'b0;
    end else begin
      size_q <= size_d;
      wait_q <= wait_d;
      en_q   <= en_d;
    end
  end

  // Region layout: even sizes, reserve slots, bases stacked in pool order
  always_comb begin
    logic [BASE_W-1:0] acc;
    acc = '0;
    for (int p = 0; p < NUM_POOLS; p++) begin
      size_even[p] = {size_q[p][SZ_W-1:1], 1'b0};
      cap[p]       = (size_even[p] >= SZ_W'(RESERVE)) ? size_even[p] - SZ_W'(RESERVE) : '0;
      base[p]      = acc;
      acc          = acc + BASE_W'(size_even[p]);
    end
  end

  assign ready  = (wait_q == '0);
  assign enable = en_q;
endmodule

// File: rtl/fpool_queue.sv
module fpool_queue #(
  parameter int SZ_W = fpool_pkg::FP_SZ_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            push,
  input  logic            pop,
  input  logic [SZ_W-1:0] size,
  input  logic [SZ_W-1:0] cap,
  output logic [SZ_W-1:0] head,
  output logic [SZ_W-1:0] tail,
  output logic [SZ_W-1:0] count,
  output logic            full,
  output logic            empty
);
  logic [SZ_W-1:0] head_d, tail_d, count_d;
  logic [SZ_W-1:0] last;

  assign last  = size - 1'b1;
  assign full  = (count >= cap);
  assign empty = (count == '0);

  always_comb begin
    head_d  = head;
    tail_d  = tail;
    count_d = count;
    if (clear) begin
      head_d  = '0;
      tail_d  = '0;
      count_d = '0;
    end else begin
      if (push) tail_d = (tail == last) ? '0 : tail + 1'b1;
      if (pop)  head_d = (head == last) ? '0 : head + 1'b1;
      case ({push, pop})
        2'b10:   count_d = count + 1'b1;
        2'b01:   count_d = count - 1'b1;
        default: count_d = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head  <= head_d;
      tail  <= tail_d;
      count <= count_d;
    end
  end
endmodule

// File: rtl/fpool_store.sv
module fpool_store #(
  parameter int DEPTH  = fpool_pkg::FP_DEPTH,
  parameter int PTR_W  = fpool_pkg::FP_PTR_W,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PTR_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [PTR_W-1:0]  rd_data
);
  logic [PTR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/fpool_alloc.sv
module fpool_alloc #(
  parameter int NUM_POOLS = fpool_pkg::FP_NUM_POOLS,
  parameter int SZ_W      = fpool_pkg::FP_SZ_W,
  parameter int DEPTH     = fpool_pkg::FP_DEPTH,
  parameter int PTR_W     = fpool_pkg::FP_PTR_W,
  parameter int CNT_W     = fpool_pkg::FP_CNT_W,
  parameter int READY_DLY = fpool_pkg::FP_READY_DLY,
  parameter int PW        = $clog2(NUM_POOLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [PW-1:0]    cfg_pool,
  input  logic [SZ_W-1:0]  cfg_size,
  input  logic             ctrl_wr,
  input  logic             ctrl_enable,
  input  logic             free_valid,
  input  logic [PW-1:0]    free_pool,
  input  logic [PTR_W-1:0] free_ptr,
  input  logic             alloc_valid,
  input  logic [PW-1:0]    alloc_pool,
  output logic             alloc_done,
  output logic [PTR_W-1:0] alloc_ptr,
  output logic             free_drop,
  output logic             ready,
  input  logic [PW-1:0]    stat_pool,
  output logic [CNT_W-1:0] stat_count
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int BASE_W = SZ_W + PW;

  logic [NUM_POOLS-1:0][SZ_W-1:0]   size_even, cap, head, tail, count;
  logic [NUM_POOLS-1:0][BASE_W-1:0] base;
  logic [NUM_POOLS-1:0]             full, empty, push, pop;
  logic                             enable, op_ok;
  logic                             free_acc, free_rej, alloc_hit;
  logic [BASE_W-1:0]                wr_sum, rd_sum;
  logic [PTR_W-1:0]                 rd_data;
  logic                             done_q, hit_q, drop_q;

  fpool_cfg #(
    .NUM_POOLS(NUM_POOLS), .SZ_W(SZ_W), .READY_DLY(READY_DLY),
    .RESERVE(fpool_pkg::FP_RESERVE), .PW(PW), .BASE_W(BASE_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pool(cfg_pool),
    .cfg_size(cfg_size), .ctrl_wr(ctrl_wr), .ctrl_enable(ctrl_enable),
    .size_even(size_even), .cap(cap), .base(base), .ready(ready),
    .enable(enable)
  );

  assign op_ok     = enable & ready;
  assign free_acc  = free_valid & op_ok & ~full[free_pool];
  assign free_rej  = free_valid & op_ok &  full[free_pool];
  assign alloc_hit = alloc_valid & op_ok & ~empty[alloc_pool];

  for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
    assign push[p] = free_acc  & (free_pool  == PW'(p));
    assign pop[p]  = alloc_hit & (alloc_pool == PW'(p));
    fpool_queue #(.SZ_W(SZ_W)) u_q (
      .clk(clk), .rst_n(rst_n), .clear(cfg_wr), .push(push[p]), .pop(pop[p]),
      .size(size_even[p]), .cap(cap[p]), .head(head[p]), .tail(tail[p]),
      .count(count[p]), .full(full[p]), .empty(empty[p])
    );
  end

  assign wr_sum = base[free_pool]  + BASE_W'(tail[free_pool]);
  assign rd_sum = base[alloc_pool] + BASE_W'(head[alloc_pool]);

  fpool_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .wr_en(free_acc), .wr_addr(wr_sum[ADDR_W-1:0]), .wr_data(free_ptr),
    .rd_en(alloc_hit), .rd_addr(rd_sum[ADDR_W-1:0]), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      hit_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      done_q <= alloc_valid;
      hit_q  <= alloc_hit;
      drop_q <= free_rej;
    end
  end

  assign alloc_done = done_q;
  assign alloc_ptr  = hit_q ? rd_data : '0;
  assign free_drop  = drop_q;
  assign stat_count = CNT_W'(count[stat_pool]);
endmodule

// File: rtl/fpool_alloc_chk.sv
module fpool_alloc_chk #(
  parameter int NUM_POOLS = 8,
  parameter int SZ_W      = 12,
  parameter int PTR_W     = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           cfg_wr,
  input logic                           ready,
  input logic                           op_ok,
  input logic                           alloc_valid,
  input logic                           alloc_done,
  input logic [PTR_W-1:0]               alloc_ptr,
  input logic                           free_valid,
  input logic                           free_drop,
  input logic [NUM_POOLS-1:0][SZ_W-1:0] count,
  input logic [NUM_POOLS-1:0][SZ_W-1:0] cap
);
  for (genvar p = 0; p < NUM_POOLS; p++) begin : g_cap
    assert_within_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count[p] <= cap[p]);
  end

  assert_drop_after_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    free_drop |-> $past(free_valid));

  assert_settle_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !ready);

  assert_refused_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !op_ok) |=> (alloc_ptr == '0));

  assert_answer_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |=> alloc_done);

  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_valid |=> !alloc_done);
endmodule

bind fpool_alloc fpool_alloc_chk #(
  .NUM_POOLS(NUM_POOLS), .SZ_W(SZ_W), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .ready(ready), .op_ok(op_ok),
  .alloc_valid(alloc_valid), .alloc_done(alloc_done), .alloc_ptr(alloc_ptr),
  .free_valid(free_valid), .free_drop(free_drop), .count(count), .cap(cap)
);

// File: tb/sim_fpool_alloc.sv
module sim_fpool_alloc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_pool = '0;
  logic [11:0] cfg_size = '0;
  logic        ctrl_wr = 1'b0;
  logic        ctrl_enable = 1'b0;
  logic        free_valid = 1'b0;
  logic [2:0]  free_pool = '0;
  logic [31:0] free_ptr = '0;
  logic        alloc_valid = 1'b0;
  logic [2:0]  alloc_pool = '0;
  logic        alloc_done;
  logic [31:0] alloc_ptr;
  logic        free_drop;
  logic        ready;
  logic [2:0]  stat_pool = '0;
  logic [25:0] stat_count;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  fpool_alloc u0 (.*);

  // entry: {op[1:0], pool[2:0], drop_expected, value[15:0]}; op 0 free, 1 alloc, 2 count
  localparam int NV = 24;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 3'd0, 1'b0, 16'h0011},  // R8 fill pool 0
    {2'd0, 3'd0, 1'b0, 16'h0022},
    {2'd0, 3'd0, 1'b0, 16'h0033},
    {2'd0, 3'd0, 1'b0, 16'h0044},
    {2'd0, 3'd0, 1'b1, 16'h0055},  // R3 size 6 -> 4 usable, drop
    {2'd2, 3'd0, 1'b0, 16'd4},     // R3 count unchanged
    {2'd0, 3'd1, 1'b0, 16'h00A1},  // R2 pool 1 written as 5 -> 2 usable
    {2'd0, 3'd1, 1'b0, 16'h00A2},
    {2'd0, 3'd1, 1'b1, 16'h00A3},  // R2 drop
    {2'd2, 3'd1, 1'b0, 16'd2},
    {2'd1, 3'd0, 1'b0, 16'h0011},  // R4 FIFO order
    {2'd1, 3'd0, 1'b0, 16'h0022},
    {2'd0, 3'd0, 1'b0, 16'h0066},  // R4 wrap within region
    {2'd0, 3'd0, 1'b0, 16'h0077},
    {2'd2, 3'd0, 1'b0, 16'd4},     // R8
    {2'd1, 3'd0, 1'b0, 16'h0033},
    {2'd1, 3'd0, 1'b0, 16'h0044},
    {2'd1, 3'd0, 1'b0, 16'h0066},
    {2'd1, 3'd0, 1'b0, 16'h0077},
    {2'd1, 3'd0, 1'b0, 16'h0000},  // R5 empty pool gives zero
    {2'd2, 3'd0, 1'b0, 16'd0},
    {2'd1, 3'd1, 1'b0, 16'h00A1},  // R2 neighbour region intact
    {2'd1, 3'd1, 1'b0, 16'h00A2},
    {2'd2, 3'd1, 1'b0, 16'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_free(input logic [2:0] p, input logic [31:0] v, output logic d);
    @(negedge clk);
    free_valid = 1'b1; free_pool = p; free_ptr = v;
    @(negedge clk);
    free_valid = 1'b0;
    d = free_drop;
  endtask

  task automatic do_alloc(input logic [2:0] p, output logic [31:0] v, output logic dn);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_pool = p;
    @(negedge clk);
    alloc_valid = 1'b0;
    v = alloc_ptr; dn = alloc_done;
  endtask

  task automatic get_count(input logic [2:0] p, output logic [25:0] c);
    stat_pool = p;
    #1;
    c = stat_count;
  endtask

  task automatic set_size(input logic [2:0] p, input logic [11:0] s);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_pool = p; cfg_size = s;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_enable(input logic e);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_enable = e;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic        d, dn;
    logic [31:0] v;
    logic [25:0] c;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", {31'd0, ready}, 32'd1);
    check("R1 alloc_done", {31'd0, alloc_done}, 32'd0);
    check("R1 free_drop", {31'd0, free_drop}, 32'd0);
    get_count(3'd0, c);
    check("R1 count", {6'd0, c}, 32'd0);

    set_size(3'd0, 12'd6);
    check("R7 ready low after size write", {31'd0, ready}, 32'd0);
    set_size(3'd1, 12'd5);
    set_size(3'd2, 12'd4);
    repeat (11) @(negedge clk);
    check("R7 ready after window", {31'd0, ready}, 32'd1);

    // R6 disabled
    do_free(3'd0, 32'h99, d);
    get_count(3'd0, c);
    check("R6 free ignored", {6'd0, c}, 32'd0);
    do_alloc(3'd0, v, dn);
    check("R6 alloc zero", v, 32'd0);
    check("R5 done while disabled", {31'd0, dn}, 32'd1);

    set_enable(1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [2:0]  pl;
      logic        dx;
      logic [15:0] val;
      {op, pl, dx, val} = VEC[i];
      if (op == 2'd0) begin
        do_free(pl, {16'd0, val}, d);
        check("R3 drop flag", {31'd0, d}, {31'd0, dx});
      end else if (op == 2'd1) begin
        do_alloc(pl, v, dn);
        check("R4 alloc ptr", v, {16'd0, val});
        check("R5 alloc done", {31'd0, dn}, 32'd1);
      end else begin
        get_count(pl, c);
        check("R8 count", {6'd0, c}, {16'd0, val});
      end
    end

    // R9 same-cycle alloc and free to different pools
    do_free(3'd0, 32'hC1, d);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_pool = 3'd0;
    free_valid = 1'b1; free_pool = 3'd2; free_ptr = 32'hB1;
    @(negedge clk);
    alloc_valid = 1'b0; free_valid = 1'b0;
    check("R9 alloc result", alloc_ptr, 32'hC1);
    get_count(3'd2, c);
    check("R9 free landed", {6'd0, c}, 32'd1);
    get_count(3'd0, c);
    check("R9 pool0 emptied", {6'd0, c}, 32'd0);

    // R7 size write clears pools and blocks traffic
    set_size(3'd3, 12'd4);
    check("R7 ready low", {31'd0, ready}, 32'd0);
    get_count(3'd2, c);
    check("R7 pools cleared", {6'd0, c}, 32'd0);
    do_free(3'd2, 32'hE1, d);
    get_count(3'd2, c);
    check("R7 free ignored in window", {6'd0, c}, 32'd0);
    do_alloc(3'd2, v, dn);
    check("R7 alloc zero in window", v, 32'd0);
    repeat (11) @(negedge clk);
    check("R7 ready again", {31'd0, ready}, 32'd1);

    // R6 disable after operation
    set_enable(1'b0);
    do_free(3'd2, 32'hD1, d);
    get_count(3'd2, c);
    check("R6 free ignored when off", {6'd0, c}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule